// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Sequencer

This block decides, for a small 8-bit processor core, whether an interrupt is taken and which one. It watches four maskable hardware requests: an external interrupt pin (active low, edge triggered), a timer request, a serial link request and a sync-processing request. It also watches the software-interrupt fetch strobe, the instruction-complete strobe and the core's interrupt mask bit. Requests are never acted on in the middle of an instruction. They are weighed only at the boundary signalled by the instruction-complete strobe.

When an interrupt is taken, the block pulses `take_o` and `set_mask_o`. It also presents the 16-bit address of the vector to fetch and marks itself in service until the core returns. The software interrupt does not depend on the mask. When the mask is clear, every hardware request that was already pending at the software-interrupt fetch goes ahead of it, and every request that arrives after the fetch goes behind it. Stacking, instruction fetch and the datapath belong to the core.

Top module: `intr_boundary_seq`

## Requirements
- R1: After reset, `take_o`, `set_mask_o` and `in_service_o` are 0 and `vec_addr_o` is 0x0000.
- R2: Requests are evaluated only in a cycle where `insn_done` is 1. When an interrupt is taken, `take_o` is 1 for the cycle after that edge. With no `insn_done`, `take_o` stays 0.
- R3: While `mask_bit` is 1, no hardware request is taken at a boundary.
- R4: When several unmasked hardware requests compete, the fixed priority from highest to lowest is the pin interrupt, the timer, the link and then sync.
- R5: The vector addresses are: software 0x3FFC, pin 0x3FFA, timer 0x3FF8, link 0x3FF6 and sync 0x3FF4. `vec_addr_o` holds the last taken vector.
- R6: `set_mask_o` pulses together with every `take_o`.
- R7: A pending software interrupt (recorded by `swi_fetch`) is taken at the next boundary even when `mask_bit` is 1.
- R8: With `mask_bit` 0, hardware requests pending when `swi_fetch` was strobed are taken before the software interrupt, even if a request of higher priority arrives after the fetch. Requests that arrive after the fetch are taken after it.
- R9: `irq_pin_n` passes through a two-stage synchroniser. A falling edge sets a pending latch, which is usable at a boundary 3 clock edges after the pin falls. A pin held low does not retrigger. The latch clears when the pin interrupt is taken.
- R10: `in_service_o` is set when an interrupt is taken and cleared by `rti` (a take in the same cycle wins).
- R11: The timer, link and sync requests are levels. A level that drops before the boundary is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | External interrupt pin, active low, falling-edge triggered |
| tmr_req | input | 1 | Timer level request |
| link_req | input | 1 | Serial link level request |
| sync_req | input | 1 | Sync-processing level request |
| swi_fetch | input | 1 | Strobe: software-interrupt instruction fetched |
| insn_done | input | 1 | Strobe: current instruction complete |
| mask_bit | input | 1 | Core interrupt mask bit |
| rti | input | 1 | Strobe: return from interrupt |
| take_o | output | 1 | Interrupt-taken pulse |
| set_mask_o | output | 1 | Request to set the mask bit |
| vec_addr_o | output | 16 | Vector location to fetch |
| in_service_o | output | 1 | An interrupt is being serviced |

## Verification
The decision is registered once, so `take_o`, `set_mask_o`, `vec_addr_o` and `in_service_o` are due in the cycle that follows the clock edge at which `insn_done` is high. The bench raises the strobe for exactly one cycle and samples at the next falling edge. A falling edge on the pin needs three edges (two synchroniser stages and the latch) before a boundary can see it. The bench therefore waits four cycles before it issues the boundary. Level requests and `swi_fetch` are applied at falling edges, at least one edge before the boundary that is meant to see them.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int HW_N   = 4;   // pin, timer, link, sync (index = priority)
  localparam int ADDR_W = 16;
  localparam int IDX_PIN  = 0;
  localparam int IDX_TMR  = 1;
  localparam int IDX_LINK = 2;
  localparam int IDX_SYNC = 3;

  // Hardware vectors sit one word apart directly below the software vector.
  function automatic logic [ADDR_W-1:0] hw_vector(input logic [ADDR_W-1:0] swi_vec,
                                                  input int idx);
    return swi_vec - ADDR_W'(2 * (idx + 1));
  endfunction
endpackage

// File: rtl/intr_pin_sync.sv
module intr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic clr,
  output logic pend
);
  // chain[0] is newest; chain[STAGES-1] is synchronised, chain[STAGES] previous
  logic [STAGES:0] chain_q, chain_n;
  logic            pend_q, pend_n;
  logic            fall;

  always_comb begin
    chain_n = {chain_q[STAGES-1:0], pin_n};
    fall    = chain_q[STAGES] & ~chain_q[STAGES-1];
    pend_n  = fall | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      pend_q  <= 1'b0;
    end else begin
      chain_q <= chain_n;
      pend_q  <= pend_n;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  // Lowest index wins.
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == 0) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_rest
      assign grant[i] = req[i] & ~|req[i-1:0];
    end
  end
  assign any = |req;
endmodule

// File: rtl/intr_boundary_seq.sv
module intr_boundary_seq
  import intr_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_SWI     = 16'h3FFC,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pin_n,
  input  logic              tmr_req,
  input  logic              link_req,
  input  logic              sync_req,
  input  logic              swi_fetch,
  input  logic              insn_done,
  input  logic              mask_bit,
  input  logic              rti,
  output logic              take_o,
  output logic              set_mask_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              in_service_o
);
  logic [HW_N-1:0]   pend, avail, old_req, grant_old, grant_new, clr_hw;
  logic              any_old, any_new, pin_pend;
  logic [HW_N-1:0]   snap_q, snap_n;
  logic              swi_q, swi_n, swi_clr;
  logic              take_q, take_n, smask_q, insvc_q, insvc_n;
  logic [ADDR_W-1:0] vec_q, vec_n;

  intr_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_n(irq_pin_n), .clr(clr_hw[IDX_PIN]), .pend(pin_pend)
  );

  always_comb begin
    pend           = '0;
    pend[IDX_PIN]  = pin_pend;
    pend[IDX_TMR]  = tmr_req;
    pend[IDX_LINK] = link_req;
    pend[IDX_SYNC] = sync_req;
    avail   = pend & {HW_N{~mask_bit}};
    old_req = snap_q & avail;
  end

  intr_prio_pick #(.N(HW_N)) u_pick_old (.req(old_req), .grant(grant_old), .any(any_old));
  intr_prio_pick #(.N(HW_N)) u_pick_new (.req(avail),   .grant(grant_new), .any(any_new));

  // Next-state decision at the instruction boundary
  always_comb begin
    take_n  = 1'b0;
    swi_clr = 1'b0;
    clr_hw  = '0;
    vec_n   = vec_q;
    if (insn_done) begin
      if (any_old) begin
        take_n = 1'b1;
        clr_hw = grant_old;
      end else if (swi_q) begin
        take_n  = 1'b1;
        swi_clr = 1'b1;
        vec_n   = VEC_SWI;
      end else if (any_new) begin
        take_n = 1'b1;
        clr_hw = grant_new;
      end
    end
    for (int i = 0; i < HW_N; i++) begin
      if (clr_hw[i]) vec_n = hw_vector(VEC_SWI, i);
    end
    swi_n = swi_fetch | (swi_q & ~swi_clr);
    if (swi_fetch)    snap_n = pend;
    else if (swi_clr) snap_n = '0;
    else              snap_n = snap_q & pend & ~clr_hw;
    insvc_n = take_n | (insvc_q & ~rti);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      swi_q   <= 1'b0;
      take_q  <= 1'b0;
      smask_q <= 1'b0;
      insvc_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      snap_q  <= snap_n;
      swi_q   <= swi_n;
      take_q  <= take_n;
      smask_q <= take_n;
      insvc_q <= insvc_n;
      if (take_n) vec_q <= vec_n;
    end
  end

  assign take_o       = take_q;
  assign set_mask_o   = smask_q;
  assign vec_addr_o   = vec_q;
  assign in_service_o = insvc_q;
endmodule

// File: rtl/intr_boundary_seq_chk.sv
module intr_boundary_seq_chk
  import intr_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_SWI = 16'h3FFC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_done,
  input logic              mask_bit,
  input logic              rti,
  input logic              take_o,
  input logic              set_mask_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic              in_service_o
);
  localparam logic [ADDR_W-1:0] VEC_LOW = VEC_SWI - ADDR_W'(2 * HW_N);

  AST_NO_IDLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_done |=> !take_o); // R2
  AST_MASKED_SWI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && mask_bit) |=> (!take_o || vec_addr_o == VEC_SWI)); // R3
  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (!vec_addr_o[0] && vec_addr_o <= VEC_SWI && vec_addr_o >= VEC_LOW)); // R5
  AST_SETMASK_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> set_mask_o); // R6
  AST_INSVC_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> in_service_o); // R10
  AST_RTI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && !insn_done) |=> !in_service_o); // R10
endmodule

bind intr_boundary_seq intr_boundary_seq_chk #(.VEC_SWI(VEC_SWI)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .mask_bit(mask_bit), .rti(rti),
  .take_o(take_o), .set_mask_o(set_mask_o), .vec_addr_o(vec_addr_o),
  .in_service_o(in_service_o)
);

// File: tb/intr_boundary_seq_tb_top.sv
module intr_boundary_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n, irq_pin_n, tmr_req, link_req, sync_req, swi_fetch, insn_done, mask_bit, rti;
  logic take_o, set_mask_o, in_service_o;
  logic [15:0] vec_addr_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intr_boundary_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .tmr_req(tmr_req),
    .link_req(link_req), .sync_req(sync_req), .swi_fetch(swi_fetch),
    .insn_done(insn_done), .mask_bit(mask_bit), .rti(rti), .take_o(take_o),
    .set_mask_o(set_mask_o), .vec_addr_o(vec_addr_o), .in_service_o(in_service_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One-cycle boundary; outputs sampled at the following falling edge.
  task automatic boundary(input bit exp_take, input logic [15:0] exp_vec, input string req);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    chk(take_o === exp_take, req, take_o, exp_take);
    chk(set_mask_o === exp_take, "R6", set_mask_o, exp_take);
    if (exp_take) chk(vec_addr_o === exp_vec, req, vec_addr_o, exp_vec);
  endtask

  task automatic do_rti();
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
  endtask

  task automatic t_reset();
    chk(take_o === 1'b0 && set_mask_o === 1'b0, "R1", {take_o, set_mask_o}, 0);
    chk(in_service_o === 1'b0, "R1", in_service_o, 0);
    chk(vec_addr_o === 16'h0000, "R1", vec_addr_o, 16'h0000);
  endtask

  task automatic t_no_boundary();
    tmr_req = 1'b1;
    cyc(3);
    chk(take_o === 1'b0, "R2", take_o, 0);
    boundary(1'b1, 16'h3FF8, "R5");
    tmr_req = 1'b0;
    cyc(1);
    chk(take_o === 1'b0, "R2", take_o, 0);
    do_rti();
  endtask

  task automatic t_priority();
    tmr_req = 1'b1; link_req = 1'b1; sync_req = 1'b1;
    cyc(1);
    boundary(1'b1, 16'h3FF8, "R4");
    tmr_req = 1'b0;
    boundary(1'b1, 16'h3FF6, "R4");
    link_req = 1'b0;
    boundary(1'b1, 16'h3FF4, "R4");
    sync_req = 1'b0;
    cyc(1);
    boundary(1'b0, 16'h0, "R4");
  endtask

  task automatic t_mask();
    mask_bit = 1'b1; link_req = 1'b1;
    cyc(1);
    boundary(1'b0, 16'h0, "R3");
    chk(vec_addr_o === 16'h3FF4, "R5", vec_addr_o, 16'h3FF4);
    mask_bit = 1'b0;
    cyc(1);
    boundary(1'b1, 16'h3FF6, "R3");
    link_req = 1'b0;
    do_rti();
  endtask

  task automatic t_rti();
    chk(in_service_o === 1'b0, "R10", in_service_o, 0);
    sync_req = 1'b1;
    cyc(1);
    boundary(1'b1, 16'h3FF4, "R10");
    sync_req = 1'b0;
    chk(in_service_o === 1'b1, "R10", in_service_o, 1);
    cyc(2);
    chk(in_service_o === 1'b1, "R10", in_service_o, 1);
    do_rti();
    chk(in_service_o === 1'b0, "R10", in_service_o, 0);
  endtask

  task automatic t_swi_masked();
    mask_bit = 1'b1; sync_req = 1'b1;
    swi_fetch = 1'b1;
    @(negedge clk);
    swi_fetch = 1'b0;
    boundary(1'b1, 16'h3FFC, "R7");
    boundary(1'b0, 16'h0, "R7");
    mask_bit = 1'b0;
    cyc(1);
    boundary(1'b1, 16'h3FF4, "R7");
    sync_req = 1'b0;
    do_rti();
  endtask

  task automatic t_order();
    tmr_req = 1'b1;
    cyc(1);
    swi_fetch = 1'b1;
    @(negedge clk);
    swi_fetch = 1'b0;
    irq_pin_n = 1'b0;
    cyc(4);
    boundary(1'b1, 16'h3FF8, "R8");
    tmr_req = 1'b0;
    boundary(1'b1, 16'h3FFC, "R8");
    boundary(1'b1, 16'h3FFA, "R8");
    boundary(1'b0, 16'h0, "R9");
    irq_pin_n = 1'b1;
    do_rti();
  endtask

  task automatic t_pin_edge();
    cyc(3);
    irq_pin_n = 1'b0;
    cyc(2);
    boundary(1'b0, 16'h0, "R9");
    cyc(1);
    boundary(1'b1, 16'h3FFA, "R9");
    cyc(4);
    boundary(1'b0, 16'h0, "R9");
    irq_pin_n = 1'b1;
    do_rti();
  endtask

  task automatic t_level_drop();
    link_req = 1'b1;
    cyc(2);
    link_req = 1'b0;
    cyc(1);
    boundary(1'b0, 16'h0, "R11");
    chk(in_service_o === 1'b0, "R11", in_service_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; irq_pin_n = 1'b1; tmr_req = 1'b0; link_req = 1'b0; sync_req = 1'b0;
    swi_fetch = 1'b0; insn_done = 1'b0; mask_bit = 1'b0; rti = 1'b0;
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_no_boundary();
    t_priority();
    do_rti();
    t_mask();
    t_rti();
    t_swi_masked();
    t_order();
    t_pin_edge();
    t_level_drop();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule